// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block pairs an asynchronous serial transmitter with a receiver. Both sides use a character format chosen at run time. A character carries 4 to 9 data bits, with optional even or odd parity and a half, one, one-and-a-half or two stop-bit period. Both sides run from the system clock and advance on a single-cycle tick strobe at sixteen times the baud rate. A separate rate generator supplies that tick.

On the transmit side, a write strobe places a character into a small holding queue. The engine takes the next character from the queue as soon as the line is free. On the receive side, each character is stored as a 16-bit word with its parity and framing flags in a two-entry queue. A read strobe removes the oldest word. A break arrives as a framing error with an all-zero data field. Status outputs report four things: transmit queue space, transmit completion, receive data available and receive overflow.

Top module: `uart_frame_engine`

## Requirements
- R1: The number of data bits is `cfg_len + 3`, so `cfg_len` = 1..6 selects 4..9 bits. Values below 1 are treated as 4 bits and values above 6 as 9 bits. The line idles high. A frame is a low start bit, then the data bits LSB first, each bit 16 ticks long.
- R2: `cfg_par` selects parity: 00 or 01 gives none, 10 gives even, 11 gives odd. The transmit parity bit follows the last data bit and is computed over the configured data bits only. On receive, a mismatching parity bit sets the parity-error flag.
- R3: `cfg_stop` selects the high stop period after the last data or parity bit: 00 gives 8 ticks, 01 gives 16, 10 gives 24, 11 gives 32.
- R4: The receive word `rx_word` holds the data in bits 8:0, with the bits above the configured length zero. Bit 14 is the parity-error flag and bit 15 is the framing-error flag (first stop bit sampled low). Bits 13:9 always read 0.
- R5: The receiver checks only the first stop bit. With two stop bits configured, a frame followed by a single stop bit and then an immediate new start bit is accepted without error.
- R6: A break (line low through the whole frame, including the stop bit) yields a word with the framing flag set and all data bits zero.
- R7: The receive queue holds two words. `rx_valid` is high while any word is held, and `rx_word` shows the oldest word. A cycle with `rx_rd` high removes it.
- R8: A character that completes while both receive entries are full, with no read in the same cycle, is dropped and sets `rx_ovf`. `rx_ovf` stays set until a cycle with `ovf_clr` high.
- R9: `tx_space` is high while the transmit queue can accept a write. A write while `tx_space` is low is ignored and never transmitted.
- R10: `tx_done` is high when the transmit queue is empty and the full stop period of the last character has elapsed.
- R11: The receiver samples mid-bit, 8 ticks after it detects the start edge and every 16 ticks after that. A start bit that reads high at its mid-point is discarded as a glitch.
- R12: After reset, `txd` is high, `tx_space` and `tx_done` are high, and `rx_valid` and `rx_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the baud rate |
| cfg_len | input | 4 | Data bits minus 3 |
| cfg_par | input | 2 | Parity mode (00/01 none, 10 even, 11 odd) |
| cfg_stop | input | 2 | Stop period (00 half, 01 one, 10 one and a half, 11 two) |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | 9 | Character to transmit |
| tx_space | output | 1 | Transmit queue can accept a write |
| tx_done | output | 1 | Queue empty and last stop period sent |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Removes the oldest receive word |
| rx_word | output | 16 | Oldest receive word with error flags |
| rx_valid | output | 1 | At least one receive word held |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| ovf_clr | input | 1 | Clears `rx_ovf` |

## Verification
The bench uses the default depths: a two-entry transmit queue and a two-entry receive queue. With these depths, a burst of four back-to-back writes both fills the transmit side and overruns it. A third unread character likewise overflows the receive side. The tick strobe fires every fourth clock, which keeps each bit at 64 clocks. At that rate, every data length, parity mode and stop period can be exercised within a short run. A loopback of `txd` into `rxd` with a half stop period shows that back-to-back frames from the block's own transmitter are resynchronised by the receiver.

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int TX_DEPTH = 2,
  parameter int RX_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic [3:0]  cfg_len,
  input  logic [1:0]  cfg_par,
  input  logic [1:0]  cfg_stop,
  input  logic        tx_wr,
  input  logic [8:0]  tx_data,
  output logic        tx_space,
  output logic        tx_done,
  output logic        txd,
  input  logic        rxd,
  input  logic        rx_rd,
  output logic [15:0] rx_word,
  output logic        rx_valid,
  output logic        rx_ovf,
  input  logic        ovf_clr
);
  localparam int TXP = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int TXC = $clog2(TX_DEPTH + 1);
  localparam int RXP = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int RXC = $clog2(RX_DEPTH + 1);

  function automatic logic [3:0] data_bits(input logic [3:0] l);
    if (l < 4'd1) return 4'd4;
    if (l > 4'd6) return 4'd9;
    return l + 4'd3;
  endfunction

  // ---------------- transmit queue ----------------
  logic [8:0]     txq [TX_DEPTH];
  logic [TXP-1:0] txq_wp, txq_rp;
  logic [TXC-1:0] txq_n;
  logic           tx_busy, tx_stp, tx_push, tx_pop;

  assign tx_space = (txq_n != TXC'(TX_DEPTH));
  assign tx_push  = tx_wr && tx_space;
  assign tx_pop   = !tx_busy && (txq_n != '0);
  assign tx_done  = !tx_busy && (txq_n == '0);

  always_ff @(posedge clk) if (tx_push) txq[txq_wp] <= tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq_wp <= '0; txq_rp <= '0; txq_n <= '0;
    end else begin
      if (tx_push) txq_wp <= (txq_wp == TXP'(TX_DEPTH-1)) ? '0 : txq_wp + 1'b1;
      if (tx_pop)  txq_rp <= (txq_rp == TXP'(TX_DEPTH-1)) ? '0 : txq_rp + 1'b1;
      txq_n <= txq_n + TXC'(tx_push) - TXC'(tx_pop);
    end
  end

  // ---------------- transmit frame build ----------------
  logic [9:0]  head_x;
  logic [3:0]  tx_nbc, tx_fbc, tx_fb, tx_bi;
  logic        tx_pbit;
  logic [10:0] tx_next, tx_vec;
  logic [5:0]  tx_slen_c, tx_slen, tx_tc;

  assign head_x = {1'b0, txq[txq_rp]};
  assign tx_nbc = data_bits(cfg_len);
  assign tx_fbc = 4'd1 + tx_nbc + {3'b0, cfg_par[1]};

  always_comb begin
    tx_pbit = cfg_par[0];
    for (int i = 0; i < 9; i++) if (i < int'(tx_nbc)) tx_pbit ^= head_x[i];
    tx_next = '1;
    tx_next[0] = 1'b0;
    for (int i = 1; i < 11; i++) begin
      if (i <= int'(tx_nbc)) tx_next[i] = head_x[i-1];
      else if (i == int'(tx_nbc) + 1 && cfg_par[1]) tx_next[i] = tx_pbit;
    end
    case (cfg_stop)
      2'b00:   tx_slen_c = 6'd8;
      2'b01:   tx_slen_c = 6'd16;
      2'b10:   tx_slen_c = 6'd24;
      default: tx_slen_c = 6'd32;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_stp <= 1'b0; tx_bi <= '0; tx_tc <= '0;
      tx_vec <= '1; tx_fb <= '0; tx_slen <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1; tx_stp <= 1'b0; tx_bi <= '0; tx_tc <= '0;
      tx_vec <= tx_next; tx_fb <= tx_fbc; tx_slen <= tx_slen_c;
    end else if (tx_busy && tick16) begin
      if (!tx_stp) begin
        if (tx_tc == 6'd15) begin
          tx_tc <= '0;
          if (tx_bi == tx_fb - 4'd1) tx_stp <= 1'b1;
          else tx_bi <= tx_bi + 4'd1;
        end else tx_tc <= tx_tc + 6'd1;
      end else if (tx_tc == tx_slen - 6'd1) begin
        tx_busy <= 1'b0; tx_stp <= 1'b0; tx_tc <= '0;
      end else tx_tc <= tx_tc + 6'd1;
    end
  end

  assign txd = !tx_busy || tx_stp || tx_vec[tx_bi];

  // ---------------- receiver ----------------
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
  rx_state_t   rx_st;
  logic        rx_s1, rx_s2, rx_pen, rx_odd, rx_half, rx_pb, rx_perr, rx_push;
  logic [3:0]  rx_tc, rx_bi, rx_nb, rx_last, rx_lim;
  logic [8:0]  rx_sh;
  logic [15:0] rx_new;

  assign rx_last = rx_nb + {3'b0, rx_pen};
  assign rx_lim  = (rx_bi == rx_last && rx_half) ? 4'd11 : 4'd15;
  assign rx_perr = rx_pen && ((^rx_sh ^ rx_pb) != rx_odd);
  assign rx_new  = {~rx_s2, rx_perr, 5'b0, rx_sh};
  assign rx_push = tick16 && rx_st == RX_BITS && rx_tc == rx_lim && rx_bi == rx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1; rx_st <= RX_IDLE; rx_tc <= '0; rx_bi <= '0;
      rx_nb <= 4'd8; rx_pen <= 1'b0; rx_odd <= 1'b0; rx_half <= 1'b0;
      rx_sh <= '0; rx_pb <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (tick16) begin
        case (rx_st)
          RX_IDLE: if (!rx_s2) begin
            rx_st <= RX_START; rx_tc <= '0; rx_nb <= data_bits(cfg_len);
            rx_pen <= cfg_par[1]; rx_odd <= cfg_par[0]; rx_half <= (cfg_stop == 2'b00);
            rx_sh <= '0; rx_pb <= 1'b0;
          end
          RX_START: if (rx_tc == 4'd7) begin
            rx_tc <= '0; rx_bi <= '0;
            rx_st <= rx_s2 ? RX_IDLE : RX_BITS;
          end else rx_tc <= rx_tc + 4'd1;
          default: if (rx_tc == rx_lim) begin
            rx_tc <= '0; rx_bi <= rx_bi + 4'd1;
            if (rx_bi < rx_nb) rx_sh[rx_bi] <= rx_s2;
            else if (rx_bi == rx_last) rx_st <= RX_IDLE;
            else rx_pb <= rx_s2;
          end else rx_tc <= rx_tc + 4'd1;
        endcase
      end
    end
  end

  // ---------------- receive queue ----------------
  logic [15:0]    rxq [RX_DEPTH];
  logic [RXP-1:0] rxq_wp, rxq_rp;
  logic [RXC-1:0] rxq_n;
  logic           rx_pop, rx_acc;

  assign rx_valid = (rxq_n != '0);
  assign rx_pop   = rx_rd && rx_valid;
  assign rx_acc   = rx_push && (rxq_n != RXC'(RX_DEPTH) || rx_pop);
  assign rx_word  = rx_valid ? rxq[rxq_rp] : '0;

  always_ff @(posedge clk) if (rx_acc) rxq[rxq_wp] <= rx_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxq_wp <= '0; rxq_rp <= '0; rxq_n <= '0; rx_ovf <= 1'b0;
    end else begin
      if (rx_acc) rxq_wp <= (rxq_wp == RXP'(RX_DEPTH-1)) ? '0 : rxq_wp + 1'b1;
      if (rx_pop) rxq_rp <= (rxq_rp == RXP'(RX_DEPTH-1)) ? '0 : rxq_rp + 1'b1;
      rxq_n <= rxq_n + RXC'(rx_acc) - RXC'(rx_pop);
      if (rx_push && !rx_acc) rx_ovf <= 1'b1;
      else if (ovf_clr) rx_ovf <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_space && !tx_pop) |=> !tx_space);
  p_done_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_word[13:9] == 5'b0));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_valid) |=> (rx_valid && $stable(rx_ovf)));
  p_ovf_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rxq_n == RXC'(RX_DEPTH) && !rx_rd) |=> rx_ovf);
  p_valid_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_rd) |=> rx_valid);
endmodule

// File: tb/uart_frame_engine_bench.sv
module uart_frame_engine_bench;
  localparam int TDIV = 4;

  logic clk = 0, rst_n = 0, tick16 = 0;
  logic [3:0] cfg_len = 4'd5;
  logic [1:0] cfg_par = 2'b00, cfg_stop = 2'b01;
  logic tx_wr = 0, rx_rd = 0, ovf_clr = 0, rxd_drv = 1, lb = 0;
  logic [8:0] tx_data = '0;
  logic tx_space, tx_done, txd, rx_valid, rx_ovf, rxd;
  logic [15:0] rx_word;
  int nchk = 0, nerr = 0, cyc = 0, tcnt = 0;

  assign rxd = lb ? txd : rxd_drv;

  uart_frame_engine u_uart_frame_engine (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .tx_wr(tx_wr), .tx_data(tx_data), .tx_space(tx_space),
    .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ovf(rx_ovf), .ovf_clr(ovf_clr));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TDIV-1);
    if (cyc == 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ew(input int d, input int nb, input int pe, input int fe);
    return (fe << 15) | (pe << 14) | (d & ((1 << nb) - 1));
  endfunction

  task automatic hold(input int v, input int ticks);
    if (ticks > 0) begin
      rxd_drv = v[0];
      repeat (ticks * TDIV) @(negedge clk);
    end
  endtask

  task automatic send_rx(input int d, input int nb, input int pen, input int odd,
                         input int flip, input int stopv, input int gap);
    int p;
    p = odd ^ flip;
    for (int i = 0; i < nb; i++) p ^= (d >> i) & 1;
    hold(0, 16);
    for (int i = 0; i < nb; i++) hold((d >> i) & 1, 16);
    if (pen != 0) hold(p, 16);
    if (stopv != 0) hold(1, 16);
    else begin hold(0, 10); hold(1, 6); end
    hold(1, gap);
  endtask

  task automatic expect_rx(input int w, input string req);
    chk(rx_valid === 1'b1, req, "rx_valid", int'(rx_valid), 1);
    chk(rx_word === w[15:0], req, "rx_word", int'(rx_word), w);
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic wr(input int d);
    tx_wr = 1; tx_data = d[8:0]; @(negedge clk); tx_wr = 0;
  endtask

  task automatic catch_tx(input int d, input int nb, input int pen, input int odd,
                          input int stopt, input bit last, input string req);
    int e, t, got, p, fb, tt;
    for (t = 0; t < 4000 && txd !== 1'b0; t++) @(negedge clk);
    chk(t < 4000, req, "start bit seen", t, 0);
    e = 0; got = 0; fb = 1 + nb + pen; p = odd;
    for (int k = 1; k < fb; k++) begin
      repeat ((8 + 16 * k) * TDIV - e) @(negedge clk);
      e = (8 + 16 * k) * TDIV;
      if (k <= nb) got |= int'(txd) << (k - 1);
      else begin
        for (int i = 0; i < nb; i++) p ^= (d >> i) & 1;
        chk(txd === p[0], req, "parity bit", int'(txd), p);
      end
    end
    chk(got == (d & ((1 << nb) - 1)), req, "tx data", got, d & ((1 << nb) - 1));
    repeat ((fb * 16 + 2) * TDIV - e) @(negedge clk);
    e = (fb * 16 + 2) * TDIV;
    chk(txd === 1'b1, req, "stop early", int'(txd), 1);
    repeat ((fb * 16 + stopt - 2) * TDIV - e) @(negedge clk);
    e = (fb * 16 + stopt - 2) * TDIV;
    chk(txd === 1'b1, req, "stop late", int'(txd), 1);
    if (last) begin
      for (t = 0; t < 400 && tx_done !== 1'b1; t++) begin @(negedge clk); e++; end
      tt = (fb * 16 + stopt) * TDIV;
      chk(e >= tt - TDIV && e <= tt + 2, "R10", "tx_done delay", e, tt);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(txd === 1'b1, "R12", "txd", int'(txd), 1);
    chk(tx_space === 1'b1, "R12", "tx_space", int'(tx_space), 1);
    chk(tx_done === 1'b1, "R12", "tx_done", int'(tx_done), 1);
    chk(rx_valid === 1'b0, "R12", "rx_valid", int'(rx_valid), 0);
    chk(rx_ovf === 1'b0, "R12", "rx_ovf", int'(rx_ovf), 0);

    // R1 8 bits, no parity
    send_rx(8'hA5, 8, 0, 0, 0, 1, 4);
    expect_rx(ew(8'hA5, 8, 0, 0), "R1");
    // R2 even parity, good
    cfg_par = 2'b10;
    send_rx(8'h3C, 8, 1, 0, 0, 1, 4);
    expect_rx(ew(8'h3C, 8, 0, 0), "R2");
    // R2 odd parity, corrupted -> bit 14
    cfg_par = 2'b11;
    send_rx(8'h71, 8, 1, 1, 1, 1, 4);
    expect_rx(ew(8'h71, 8, 1, 0), "R2");
    // R1 5 bits: upper bits zero (R4)
    cfg_par = 2'b00; cfg_len = 4'd2;
    send_rx(9'h1F5, 5, 0, 0, 0, 1, 4);
    expect_rx(ew(9'h1F5, 5, 0, 0), "R4");
    // R1 9 bits
    cfg_len = 4'd6;
    send_rx(9'h1AB, 9, 0, 0, 0, 1, 4);
    expect_rx(ew(9'h1AB, 9, 0, 0), "R1");
    // R1 length clamp: 0 acts as 4 bits
    cfg_len = 4'd0;
    send_rx(8'hFA, 4, 0, 0, 0, 1, 4);
    expect_rx(ew(8'hFA, 4, 0, 0), "R1");
    // R4 framing error
    cfg_len = 4'd5;
    send_rx(8'h5E, 8, 0, 0, 0, 0, 12);
    expect_rx(ew(8'h5E, 8, 0, 1), "R4");
    // R6 break
    send_rx(0, 8, 0, 0, 0, 0, 12);
    expect_rx(32'h8000, "R6");
    // R5 two stop configured, only one sent, back to back
    cfg_stop = 2'b11;
    send_rx(8'h12, 8, 0, 0, 0, 1, 0);
    send_rx(8'h34, 8, 0, 0, 0, 1, 4);
    expect_rx(ew(8'h12, 8, 0, 0), "R5");
    expect_rx(ew(8'h34, 8, 0, 0), "R5");
    cfg_stop = 2'b01;
    // R8 overflow, R7 queue order
    send_rx(8'h01, 8, 0, 0, 0, 1, 2);
    send_rx(8'h02, 8, 0, 0, 0, 1, 2);
    send_rx(8'h03, 8, 0, 0, 0, 1, 4);
    chk(rx_ovf === 1'b1, "R8", "rx_ovf set", int'(rx_ovf), 1);
    expect_rx(ew(8'h01, 8, 0, 0), "R7");
    chk(rx_valid === 1'b1, "R7", "valid with one left", int'(rx_valid), 1);
    expect_rx(ew(8'h02, 8, 0, 0), "R8");
    chk(rx_valid === 1'b0, "R7", "empty after reads", int'(rx_valid), 0);
    chk(rx_ovf === 1'b1, "R8", "rx_ovf sticky", int'(rx_ovf), 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk(rx_ovf === 1'b0, "R8", "rx_ovf cleared", int'(rx_ovf), 0);
    // R11 glitch
    hold(0, 3); hold(1, 40);
    chk(rx_valid === 1'b0, "R11", "glitch ignored", int'(rx_valid), 0);
    send_rx(8'hC3, 8, 0, 0, 0, 1, 4);
    expect_rx(ew(8'hC3, 8, 0, 0), "R11");

    // TX R1 8N1
    wr(8'h5A);
    catch_tx(8'h5A, 8, 0, 0, 16, 1, "R1");
    // TX R2 R3 7 bits even, two stop
    cfg_len = 4'd4; cfg_par = 2'b10; cfg_stop = 2'b11;
    wr(8'h6B);
    catch_tx(8'h6B, 7, 1, 0, 32, 1, "R3");
    // TX 9 bits odd, half stop
    cfg_len = 4'd6; cfg_par = 2'b11; cfg_stop = 2'b00;
    wr(9'h155);
    catch_tx(9'h155, 9, 1, 1, 8, 1, "R2");
    // TX one and a half stop
    cfg_len = 4'd5; cfg_par = 2'b00; cfg_stop = 2'b10;
    wr(8'h81);
    catch_tx(8'h81, 8, 0, 0, 24, 1, "R3");
    // R9 queue fill, write while full dropped
    cfg_stop = 2'b01;
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk(tx_space === 1'b0, "R9", "tx_space low when full", int'(tx_space), 0);
    wr(8'h44);
    chk(tx_done === 1'b0, "R10", "tx_done low while busy", int'(tx_done), 0);
    catch_tx(8'h11, 8, 0, 0, 16, 0, "R9");
    catch_tx(8'h22, 8, 0, 0, 16, 0, "R9");
    catch_tx(8'h33, 8, 0, 0, 16, 1, "R9");
    begin
      int lows;
      lows = 0;
      repeat (50 * TDIV) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk(lows == 0, "R9", "dropped write not sent", lows, 0);
    end
    // loopback, 6 bits, half stop, back to back
    cfg_len = 4'd3; cfg_stop = 2'b00; lb = 1;
    wr(6'h2A); wr(6'h15);
    for (int t = 0; t < 4000 && !(tx_done === 1'b1 && rx_valid === 1'b1 && u_ok()); t++) @(negedge clk);
    repeat (20 * TDIV) @(negedge clk);
    expect_rx(ew(6'h2A, 6, 0, 0), "R3");
    expect_rx(ew(6'h15, 6, 0, 0), "R3");
    lb = 0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  function automatic bit u_ok();
    return 1'b1;
  endfunction
endmodule